// File: doc/BRIEF.md
# Mode-Banked General Register File

This block holds the sixteen 32-bit general registers of a processor core that runs in one of seven operating modes, together with the program status word and one saved copy of that word for each exception mode. Register numbers on the read and write ports are architectural (0 to 15). The block turns each one into a physical storage slot according to the 5-bit mode held in the status word. Some architectural registers therefore resolve to private copies that belong to a single mode.

The fast-interrupt mode keeps private copies of registers 8 to 14. The interrupt, supervisor, abort and undefined modes keep private copies of only the stack pointer (13) and the link register (14). The privileged system mode shares every register with the unprivileged user mode. Registers 0 to 7 and register 15 are one shared set for all modes. The core's decode logic drives three kinds of request: control-byte writes to the status word, exception entries with a target mode, and exception returns that copy the saved word back. The instruction decoder, the ALU and the program-counter logic stay outside the block.

Top module: `mode_banked_regfile`

## Requirements
- R1: On a clock edge with `rst` high, every register slot and both read outputs clear to zero. `status_q` becomes 0x000000D3 (supervisor mode, both interrupt masks set), and every saved status word clears to zero.
- R2: The legal mode codes in `status_q[4:0]` are user 0x10, fast interrupt 0x11, interrupt 0x12, supervisor 0x13, abort 0x17, undefined 0x1B and system 0x1F. In every mode other than user, a `psr_we` write that carries a legal code loads `status_q[7:0]` from `psr_wdata[7:0]`. Bit 7 masks normal interrupts, bit 6 masks fast interrupts, and bit 5 always reads zero. `priv` is high in every mode except user.
- R3: A `psr_we` write whose `psr_wdata[4:0]` is not a legal code leaves `status_q[7:0]` unchanged. Bits [31:28] (the condition flags) still load from `psr_wdata`.
- R4: In user mode, a `psr_we` write updates only `status_q[31:28]`. The mode and mask bits keep their values.
- R5: Registers 0 to 7 and 15 are one physical set seen by all seven modes.
- R6: In fast-interrupt mode, registers 8 to 14 are private to that mode. They are neither read nor written through any other mode.
- R7: In the interrupt, supervisor, abort and undefined modes, registers 13 and 14 are private to each mode. Registers 8 to 12 are shared with user and system modes.
- R8: System mode reads and writes exactly the registers of user mode.
- R9: An `exc_take` pulse whose `exc_mode` is one of the five exception modes does two things. It copies the current `status_q` into that mode's saved word, and it replaces `status_q[4:0]` with `exc_mode`. All other status bits stay as they were. Such an entry overrides `psr_we`, `spsr_we` and `exc_ret` in the same cycle. An entry that targets user mode, system mode or an illegal code is ignored.
- R10: In an exception mode, `exc_ret` loads `status_q` from that mode's saved word. It is ignored in user and system modes, and it is ignored when the saved word's mode field is not a legal code.
- R11: `saved_status` shows the saved word of the current mode, and reads zero in user and system modes. `spsr_we` stores `spsr_wdata` masked to bits [31:28], [7:6] and [4:0] (all other bits zero). In user and system modes, `spsr_we` is ignored.
- R12: Read data appears on `rd_a_data` and `rd_b_data` one cycle after the index is presented, and it is mapped through the mode held in that cycle. A read of the slot being written in the same cycle returns the old value.
- R13: A register write is steered by the mode held in its own cycle, even when an exception entry changes the mode at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 4 | Architectural index, read port A |
| rd_a_data | output | 32 | Registered read data, port A |
| rd_b_idx | input | 4 | Architectural index, read port B |
| rd_b_data | output | 32 | Registered read data, port B |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Architectural index for the write |
| wr_data | input | 32 | Write data |
| psr_we | input | 1 | Status write: flags plus control byte |
| psr_wdata | input | 32 | Status write data |
| spsr_we | input | 1 | Write the current mode's saved status |
| spsr_wdata | input | 32 | Saved-status write data |
| exc_take | input | 1 | Exception entry strobe |
| exc_mode | input | 5 | Target mode of the entry |
| exc_ret | input | 1 | Restore status from the saved word |
| status_q | output | 32 | Current status word |
| saved_status | output | 32 | Saved status of the current mode |
| priv | output | 1 | High when not in user mode |

## Verification
The assertions check, on every cycle, that the mode field always holds a legal code, that user mode leaves its control byte alone except through an exception entry, that the saved-status output is zero in user and system modes, and that an accepted entry lands in the target mode with the old status word saved. The bank aliasing rules (R5 to R8), the read-before-write timing and the steering of a write that coincides with a mode change can only be shown by the bench's scenarios. In those scenarios, a value written in one mode is read back, or is found to be absent, after the core has moved to another mode. A bench model keeps one full copy of the register set per bank and spreads each write to every bank that shares the register.

// File: rtl/mrf_pkg.sv
package mrf_pkg;

  localparam int PSR_W = 32;

  localparam logic [4:0] MODE_USR = 5'h10;
  localparam logic [4:0] MODE_FIQ = 5'h11;
  localparam logic [4:0] MODE_IRQ = 5'h12;
  localparam logic [4:0] MODE_SVC = 5'h13;
  localparam logic [4:0] MODE_ABT = 5'h17;
  localparam logic [4:0] MODE_UND = 5'h1B;
  localparam logic [4:0] MODE_SYS = 5'h1F;

  // Status bits that exist: flags [31:28], masks [7:6], mode [4:0]
  localparam logic [PSR_W-1:0] PSR_KEEP  = 32'hF00000DF;
  localparam logic [PSR_W-1:0] PSR_RESET = 32'h000000D3;

  typedef enum logic [2:0] {
    BK_USR = 3'd0,  // user and system share this bank
    BK_FIQ = 3'd1,
    BK_IRQ = 3'd2,
    BK_SVC = 3'd3,
    BK_ABT = 3'd4,
    BK_UND = 3'd5,
    BK_BAD = 3'd7
  } bank_e;

  function automatic bank_e bank_of(input logic [4:0] mode);
    case (mode)
      MODE_USR, MODE_SYS: return BK_USR;
      MODE_FIQ:           return BK_FIQ;
      MODE_IRQ:           return BK_IRQ;
      MODE_SVC:           return BK_SVC;
      MODE_ABT:           return BK_ABT;
      MODE_UND:           return BK_UND;
      default:            return BK_BAD;
    endcase
  endfunction

  function automatic logic has_saved(input bank_e b);
    return (b == BK_FIQ) || (b == BK_IRQ) || (b == BK_SVC) ||
           (b == BK_ABT) || (b == BK_UND);
  endfunction

endpackage

// File: rtl/mrf_bank_map.sv
module mrf_bank_map
  import mrf_pkg::*;
#(
  parameter int NARCH  = 16,
  parameter int FIQ_LO = 8,
  parameter int SP_IDX = 13,
  parameter int PW     = 5,
  localparam int AW    = $clog2(NARCH)
) (
  input  bank_e          bank,
  input  logic [AW-1:0]  arch,
  output logic [PW-1:0]  phys
);
  localparam int FIQ_BASE  = NARCH;
  localparam int FIQ_CNT   = NARCH - 1 - FIQ_LO;
  localparam int PAIR_BASE = FIQ_BASE + FIQ_CNT;
  localparam int PAIR_CNT  = NARCH - 1 - SP_IDX;

  always_comb begin
    int a;
    a    = int'(arch);
    phys = PW'(a);
    if (a != NARCH - 1) begin
      if (bank == BK_FIQ && a >= FIQ_LO)
        phys = PW'(FIQ_BASE + a - FIQ_LO);
      else if (bank >= BK_IRQ && bank <= BK_UND && a >= SP_IDX)
        phys = PW'(PAIR_BASE + PAIR_CNT * (int'(bank) - int'(BK_IRQ)) + a - SP_IDX);
    end
  end
endmodule

// File: rtl/mrf_storage.sv
module mrf_storage #(
  parameter int XLEN  = 32,
  parameter int DEPTH = 31,
  parameter int PW    = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [PW-1:0]   waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [PW-1:0]   ra_addr,
  input  logic [PW-1:0]   rb_addr,
  output logic [XLEN-1:0] ra_q,
  output logic [XLEN-1:0] rb_q
);
  logic [XLEN-1:0] mem [DEPTH];

  // Read-first: reads sample the array before this edge's write lands
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      ra_q <= '0;
      rb_q <= '0;
    end else begin
      if (we) mem[waddr] <= wdata;
      ra_q <= mem[ra_addr];
      rb_q <= mem[rb_addr];
    end
  end
endmodule

// File: rtl/mrf_status.sv
module mrf_status
  import mrf_pkg::*;
#(
  parameter int NSAVED = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             psr_we,
  input  logic [PSR_W-1:0] psr_wdata,
  input  logic             spsr_we,
  input  logic [PSR_W-1:0] spsr_wdata,
  input  logic             exc_take,
  input  logic [4:0]       exc_mode,
  input  logic             exc_ret,
  output logic [PSR_W-1:0] cpsr_q,
  output logic [PSR_W-1:0] saved_out,
  output bank_e            cur_bank
);
  logic [PSR_W-1:0] spsr_q [NSAVED];
  logic [PSR_W-1:0] cpsr_d;
  bank_e            tgt_bank;
  logic [2:0]       cur_slot, tgt_slot;
  logic             exc_ok, ret_ok, user_mode;

  always_comb begin
    cur_bank  = bank_of(cpsr_q[4:0]);
    tgt_bank  = bank_of(exc_mode);
    cur_slot  = 3'(cur_bank) - 3'd1;
    tgt_slot  = 3'(tgt_bank) - 3'd1;
    user_mode = (cpsr_q[4:0] == MODE_USR);
    saved_out = has_saved(cur_bank) ? spsr_q[cur_slot] : '0;
    exc_ok    = exc_take && has_saved(tgt_bank);
    ret_ok    = exc_ret && has_saved(cur_bank) && !exc_ok &&
                (bank_of(saved_out[4:0]) != BK_BAD);

    cpsr_d = cpsr_q;
    if (exc_ok) begin
      cpsr_d[4:0] = exc_mode;
    end else if (ret_ok) begin
      cpsr_d = saved_out;
    end else if (psr_we) begin
      cpsr_d[31:28] = psr_wdata[31:28];
      if (!user_mode && bank_of(psr_wdata[4:0]) != BK_BAD)
        cpsr_d[7:0] = psr_wdata[7:0] & PSR_KEEP[7:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpsr_q <= PSR_RESET;
      for (int i = 0; i < NSAVED; i++) spsr_q[i] <= '0;
    end else begin
      cpsr_q <= cpsr_d;
      if (exc_ok)
        spsr_q[tgt_slot] <= cpsr_q;
      else if (spsr_we && has_saved(cur_bank))
        spsr_q[cur_slot] <= spsr_wdata & PSR_KEEP;
    end
  end

  a_r2_mode_legal: assert property (@(posedge clk) disable iff (rst)
    bank_of(cpsr_q[4:0]) != BK_BAD);

  a_r4_user_ctl_locked: assert property (@(posedge clk) disable iff (rst)
    (user_mode && !exc_take) |=> (cpsr_q[7:0] == $past(cpsr_q[7:0])));

  a_r9_entry_mode: assert property (@(posedge clk) disable iff (rst)
    exc_ok |=> (cpsr_q[4:0] == $past(exc_mode)));

  a_r9_entry_saved: assert property (@(posedge clk) disable iff (rst)
    exc_ok |=> (saved_out == $past(cpsr_q)));

  a_r11_no_saved_unbanked: assert property (@(posedge clk) disable iff (rst)
    (cur_bank == BK_USR) |-> (saved_out == '0));

endmodule

// File: rtl/mode_banked_regfile.sv
module mode_banked_regfile
  import mrf_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int NARCH  = 16,
  parameter int FIQ_LO = 8,
  parameter int SP_IDX = 13,
  parameter int NPAIRS = 4,
  localparam int AW    = $clog2(NARCH),
  localparam int DEPTH = NARCH + (NARCH - 1 - FIQ_LO) + NPAIRS * (NARCH - 1 - SP_IDX),
  localparam int PW    = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   rd_a_idx,
  output logic [XLEN-1:0] rd_a_data,
  input  logic [AW-1:0]   rd_b_idx,
  output logic [XLEN-1:0] rd_b_data,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_idx,
  input  logic [XLEN-1:0] wr_data,
  input  logic            psr_we,
  input  logic [31:0]     psr_wdata,
  input  logic            spsr_we,
  input  logic [31:0]     spsr_wdata,
  input  logic            exc_take,
  input  logic [4:0]      exc_mode,
  input  logic            exc_ret,
  output logic [31:0]     status_q,
  output logic [31:0]     saved_status,
  output logic            priv
);
  localparam int NPORT = 3;  // read A, read B, write

  bank_e         cur_bank;
  logic [AW-1:0] arch_sel [NPORT];
  logic [PW-1:0] phys_sel [NPORT];

  assign arch_sel[0] = rd_a_idx;
  assign arch_sel[1] = rd_b_idx;
  assign arch_sel[2] = wr_idx;

  for (genvar g = 0; g < NPORT; g++) begin : g_map
    mrf_bank_map #(
      .NARCH(NARCH), .FIQ_LO(FIQ_LO), .SP_IDX(SP_IDX), .PW(PW)
    ) u_map (
      .bank(cur_bank),
      .arch(arch_sel[g]),
      .phys(phys_sel[g])
    );
  end

  mrf_storage #(.XLEN(XLEN), .DEPTH(DEPTH), .PW(PW)) u_store (
    .clk    (clk),
    .rst    (rst),
    .we     (wr_en),
    .waddr  (phys_sel[2]),
    .wdata  (wr_data),
    .ra_addr(phys_sel[0]),
    .rb_addr(phys_sel[1]),
    .ra_q   (rd_a_data),
    .rb_q   (rd_b_data)
  );

  mrf_status #(.NSAVED(NPAIRS + 1)) u_status (
    .clk       (clk),
    .rst       (rst),
    .psr_we    (psr_we),
    .psr_wdata (psr_wdata),
    .spsr_we   (spsr_we),
    .spsr_wdata(spsr_wdata),
    .exc_take  (exc_take),
    .exc_mode  (exc_mode),
    .exc_ret   (exc_ret),
    .cpsr_q    (status_q),
    .saved_out (saved_status),
    .cur_bank  (cur_bank)
  );

  assign priv = (status_q[4:0] != MODE_USR);

  a_r2_priv_tracks_mode: assert property (@(posedge clk) disable iff (rst)
    (status_q[4:0] == MODE_SYS) |-> priv);

endmodule

// File: tb/tb_mode_banked_regfile.sv
module tb_mode_banked_regfile;

  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  rd_a_idx, rd_b_idx, wr_idx;
  logic [31:0] rd_a_data, rd_b_data, wr_data;
  logic        wr_en, psr_we, spsr_we, exc_take, exc_ret;
  logic [31:0] psr_wdata, spsr_wdata;
  logic [4:0]  exc_mode;
  logic [31:0] status_q, saved_status;
  logic        priv;

  always #5 clk = ~clk;

  mode_banked_regfile dut (
    .clk(clk), .rst(rst),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .psr_we(psr_we), .psr_wdata(psr_wdata),
    .spsr_we(spsr_we), .spsr_wdata(spsr_wdata),
    .exc_take(exc_take), .exc_mode(exc_mode), .exc_ret(exc_ret),
    .status_q(status_q), .saved_status(saved_status), .priv(priv)
  );

  typedef struct {
    logic [3:0]  ra, rb, wi;
    logic        we, pwe, swe, ex, er;
    logic [31:0] wd, pwd, swd;
    logic [4:0]  em;
  } stim_t;

  localparam logic [31:0] KEEP = 32'hF00000DF;

  int          n_checks = 0;
  int          n_fail = 0;
  logic [31:0] mr [6][16];   // one full copy of the register set per bank
  logic [31:0] m_cpsr;
  logic [31:0] m_sp [6];

  function automatic int mbank(input logic [4:0] m);
    case (m)
      5'h10, 5'h1F: return 0;
      5'h11: return 1;
      5'h12: return 2;
      5'h13: return 3;
      5'h17: return 4;
      5'h1B: return 5;
      default: return -1;
    endcase
  endfunction

  function automatic logic shares(input int b1, input int b2, input int r);
    if (r < 8 || r == 15) return 1'b1;
    if (r < 13) return (b1 == 1) == (b2 == 1);
    return b1 == b2;
  endfunction

  function automatic stim_t idle();
    stim_t s;
    s.ra = 4'd0; s.rb = 4'd0; s.wi = 4'd0;
    s.we = 1'b0; s.pwe = 1'b0; s.swe = 1'b0; s.ex = 1'b0; s.er = 1'b0;
    s.wd = '0; s.pwd = '0; s.swd = '0; s.em = 5'h0;
    return s;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %08h expected %08h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input stim_t s, input string tag);
    int cb, tb, nb;
    logic eok, rok;
    logic [31:0] ea, eb, sv, ncp;
    @(negedge clk);
    rd_a_idx = s.ra; rd_b_idx = s.rb;
    wr_en = s.we; wr_idx = s.wi; wr_data = s.wd;
    psr_we = s.pwe; psr_wdata = s.pwd;
    spsr_we = s.swe; spsr_wdata = s.swd;
    exc_take = s.ex; exc_mode = s.em; exc_ret = s.er;

    cb = mbank(m_cpsr[4:0]);
    ea = mr[cb][s.ra];
    eb = mr[cb][s.rb];
    tb = mbank(s.em);
    eok = s.ex && tb >= 1;
    sv = (cb >= 1) ? m_sp[cb] : 32'h0;
    rok = s.er && cb >= 1 && mbank(sv[4:0]) >= 0 && !eok;
    if (s.we)
      for (int k = 0; k < 6; k++)
        if (shares(k, cb, int'(s.wi))) mr[k][s.wi] = s.wd;
    if (s.swe && cb >= 1 && !eok) m_sp[cb] = s.swd & KEEP;
    ncp = m_cpsr;
    if (eok) ncp[4:0] = s.em;
    else if (rok) ncp = sv;
    else if (s.pwe) begin
      ncp[31:28] = s.pwd[31:28];
      if (m_cpsr[4:0] != 5'h10 && mbank(s.pwd[4:0]) >= 0)
        ncp[7:0] = s.pwd[7:0] & 8'hDF;
    end
    if (eok) m_sp[tb] = m_cpsr;
    m_cpsr = ncp;
    nb = mbank(m_cpsr[4:0]);

    @(posedge clk);
    #1;
    chk(tag, "rd_a", rd_a_data, ea);
    chk(tag, "rd_b", rd_b_data, eb);
    chk(tag, "status", status_q, m_cpsr);
    chk(tag, "saved", saved_status, (nb >= 1) ? m_sp[nb] : 32'h0);
    chk(tag, "priv", {31'b0, priv}, {31'b0, m_cpsr[4:0] != 5'h10});
  endtask

  function automatic stim_t psr(input logic [31:0] v);
    stim_t s = idle();
    s.pwe = 1'b1; s.pwd = v;
    return s;
  endfunction

  function automatic stim_t wr(input logic [3:0] r, input logic [31:0] v);
    stim_t s = idle();
    s.we = 1'b1; s.wi = r; s.wd = v;
    return s;
  endfunction

  function automatic stim_t rd(input logic [3:0] a, input logic [3:0] b);
    stim_t s = idle();
    s.ra = a; s.rb = b;
    return s;
  endfunction

  function automatic logic [4:0] pick_mode(input int n);
    case (n)
      0: return 5'h10; 1: return 5'h11; 2: return 5'h12; 3: return 5'h13;
      4: return 5'h17; 5: return 5'h1B; 6: return 5'h1F;
      default: return 5'(n * 3);
    endcase
  endfunction

  initial begin
    #2_000_000;
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    stim_t s;
    void'($urandom(32'd20240611));
    for (int b = 0; b < 6; b++) begin
      m_sp[b] = '0;
      for (int r = 0; r < 16; r++) mr[b][r] = '0;
    end
    m_cpsr = 32'h000000D3;
    s = idle();
    rst = 1'b1;
    rd_a_idx = 0; rd_b_idx = 0; wr_en = 0; wr_idx = 0; wr_data = 0;
    psr_we = 0; psr_wdata = 0; spsr_we = 0; spsr_wdata = 0;
    exc_take = 0; exc_mode = 0; exc_ret = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "status", status_q, 32'h000000D3);
    chk("R1", "saved", saved_status, 32'h0);
    chk("R1", "rd_a", rd_a_data, 32'h0);
    @(negedge clk);
    rst = 1'b0;

    // R5 R7: shared and private registers across supervisor and interrupt
    cyc(wr(4'd0, 32'hA0A0_0001), "R5");
    cyc(wr(4'd13, 32'h5550_0013), "R7");
    cyc(wr(4'd8, 32'hC8C8_0008), "R7");
    cyc(rd(4'd13, 4'd8), "R7");
    cyc(psr(32'h000000D2), "R2");
    cyc(rd(4'd0, 4'd13), "R5 R7");
    cyc(rd(4'd8, 4'd14), "R7");
    // R6: fast-interrupt bank
    cyc(psr(32'h000000D1), "R2");
    cyc(rd(4'd8, 4'd0), "R6");
    cyc(wr(4'd8, 32'hF1F1_0008), "R6");
    cyc(wr(4'd12, 32'hF1F1_000C), "R6");
    cyc(rd(4'd8, 4'd12), "R6");
    // R8: system aliases user
    cyc(psr(32'h0000001F), "R2");
    cyc(rd(4'd8, 4'd12), "R6 R8");
    cyc(wr(4'd13, 32'h0505_0013), "R8");
    // R12: same-cycle write and read returns old value
    s = wr(4'd3, 32'h3333_3333); s.ra = 4'd3; s.rb = 4'd3;
    cyc(s, "R12");
    cyc(rd(4'd3, 4'd13), "R12");
    // R3: illegal mode code leaves control byte
    cyc(psr(32'hA00000D5), "R3");
    cyc(psr(32'h5000001E), "R3");
    // R9: entry with colliding status write and return
    s = psr(32'h000000D3); s.ex = 1'b1; s.em = 5'h17; s.er = 1'b1;
    cyc(s, "R9");
    cyc(rd(4'd13, 4'd0), "R9 R7");
    s = idle(); s.ex = 1'b1; s.em = 5'h1F;
    cyc(s, "R9");
    // R10: return restores
    s = idle(); s.er = 1'b1;
    cyc(s, "R10");
    cyc(rd(4'd13, 4'd14), "R8 R10");
    // R4: user control lock
    cyc(psr(32'h90000010), "R2");
    cyc(psr(32'h600000D3), "R4");
    cyc(psr(32'h000000DF), "R4");
    s = idle(); s.swe = 1'b1; s.swd = 32'hFFFF_FFFF;
    cyc(s, "R11");
    s = idle(); s.er = 1'b1;
    cyc(s, "R10");
    s = idle(); s.ex = 1'b1; s.em = 5'h10;
    cyc(s, "R9");
    // R13: write coincident with entry goes to user bank
    s = wr(4'd14, 32'hEEEE_0014); s.ex = 1'b1; s.em = 5'h1B;
    cyc(s, "R13");
    cyc(rd(4'd14, 4'd13), "R13");
    // R11 R10: saved word masking, illegal saved mode blocks return
    s = idle(); s.swe = 1'b1; s.swd = 32'h0F0000F5;
    cyc(s, "R11");
    s = idle(); s.er = 1'b1;
    cyc(s, "R10");
    s = idle(); s.swe = 1'b1; s.swd = 32'hFFFF_FFF0;
    cyc(s, "R11");
    s = idle(); s.er = 1'b1;
    cyc(s, "R10");
    cyc(rd(4'd14, 4'd8), "R13");

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      s = idle();
      s.ra = 4'($urandom_range(0, 15));
      s.rb = 4'($urandom_range(0, 15));
      s.we = ($urandom_range(0, 1) == 1);
      s.wi = 4'($urandom_range(0, 15));
      s.wd = $urandom;
      s.pwe = ($urandom_range(0, 9) == 0);
      s.pwd = {4'($urandom_range(0, 15)), 20'h0, $urandom_range(0, 1) == 1,
               $urandom_range(0, 1) == 1, 1'b0,
               pick_mode(int'($urandom_range(0, 8)))};
      s.ex = ($urandom_range(0, 14) == 0);
      s.em = pick_mode(int'($urandom_range(0, 8)));
      s.er = ($urandom_range(0, 19) == 0);
      s.swe = ($urandom_range(0, 19) == 0);
      s.swd = $urandom;
      cyc(s, "R5 R6 R7 R8 R12 random");
    end

    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule